// File: doc/BRIEF.md
# Serial flash command sequencer

This block sits between a host controller and a page-organised serial flash device reached over four wires: a serial clock, a data line toward the device, a data line back from it, and an active-low select. The host picks one of three operations with a start pulse: read from main memory, fill one of the device's two internal buffers, or commit a buffer into a main-memory page. The sequencer asserts select and shifts out the opcode and address frame that fits the operation. It then moves the requested number of data bytes in either direction and releases select.

Before each command the block waits for the device's ready line to be high. This lets a page program that is still running inside the device finish before the next command goes out. Read bytes come back to the host with a one-cycle strobe. Write bytes are pulled from the host one at a time with a ready/valid pair. The serial clock runs at the system clock divided by `2*HALF_CYC`.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is low, and after it is released, select is high, the serial clock is low and busy, write-ready and read-valid are low. Asserting reset during a command ends it at once.
- R2: Operation code 0 (read) sends opcode 52h, then two zero bits, the 12-bit page and the 10-bit byte offset, then 32 zero filler bits, all most-significant bit first.
- R3: Operation code 1 (buffer write) sends opcode 84h when buffer select is 0 and 87h when it is 1, then 14 zero bits and the 10-bit byte offset.
- R4: Operation code 2 (page program) sends opcode 83h when buffer select is 0 and 86h when it is 1, then two zero bits, the 12-bit page and 10 zero bits. It carries no data phase, whatever the length input says.
- R5: After a read frame, the block clocks in exactly `len` bytes, each sampled on rising serial clock edges most-significant bit first. Each byte is delivered on `rd_data_o` with a one-cycle `rd_valid_o` pulse.
- R6: After a buffer-write frame, the block raises `wr_ready_o` for each of `len` bytes. It accepts a byte on a cycle with both `wr_valid_o`-side strobe `wr_valid_i` and `wr_ready_o` high, and shifts it out most-significant bit first.
- R7: A length of zero produces a frame with no data phase: exactly 64 clocks for a read and 32 for a buffer write.
- R8: Each command uses exactly one select-low window. The serial clock rises only while select is low and idles low. The data line toward the device holds steady while the clock is high.
- R9: While the ready input is low, an accepted command keeps busy high and select high, and sends no clock.
- R10: A start pulse while busy is ignored, and so is a start with operation code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| start_i | input | 1 | One-cycle command request |
| op_i | input | 2 | 0 read, 1 buffer write, 2 page program, 3 reserved |
| buf_sel_i | input | 1 | Device buffer: 0 first, 1 second |
| page_i | input | 12 | Main-memory page number |
| byte_i | input | 10 | Byte offset within page or buffer |
| len_i | input | LEN_W | Data byte count |
| wr_valid_i | input | 1 | Host offers a write byte |
| wr_data_i | input | 8 | Write byte |
| wr_ready_o | output | 1 | Sequencer waits for a write byte |
| rd_valid_o | output | 1 | One-cycle strobe for a read byte |
| rd_data_o | output | 8 | Read byte |
| busy_o | output | 1 | A command is in progress |
| flash_rdy_i | input | 1 | Device ready indication |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data toward the device |
| miso_i | input | 1 | Serial data from the device |
| cs_n_o | output | 1 | Active-low device select |

## Verification
A device model in the bench records every bit on rising serial clock edges and returns a seeded byte pattern on falling ones. The sweep runs all three operations with both buffer selects, four page/offset pairs and lengths 0, 1 and 3. The page and offset values include all-zeros, all-ones and two alternating patterns. All-zero and all-one addresses expose stuck or shifted fields. The alternating ones expose swapped or mis-ordered bits, and the two buffer selects separate the opcode pairs. The length sweep shows that the byte counter stops on the right byte in each direction, and that the program command ignores length. Separate runs cover a held-low ready line, a stray start during a write, a reserved operation code and a reset in mid-read.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_BUFWR = 2'd1,
    OP_PROG  = 2'd2,
    OP_NONE  = 2'd3
  } fseq_op_e;

  localparam int unsigned PAGE_W  = 12;
  localparam int unsigned COL_W   = 10;
  localparam int unsigned ADDR_W  = 24;
  localparam int unsigned FILL_W  = 32;
  localparam int unsigned FRAME_W = 8 + ADDR_W + FILL_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  function automatic logic [7:0] opcode_of(fseq_op_e op, logic bsel);
    case (op)
      OP_READ:  opcode_of = 8'h52;
      OP_BUFWR: opcode_of = bsel ? 8'h87 : 8'h84;
      OP_PROG:  opcode_of = bsel ? 8'h86 : 8'h83;
      default:  opcode_of = 8'h00;
    endcase
  endfunction

  // Left-aligned command frame; unused tail bits are zero.
  function automatic logic [FRAME_W-1:0] frame_of(fseq_op_e op, logic bsel,
                                                  logic [PAGE_W-1:0] page,
                                                  logic [COL_W-1:0] col);
    logic [ADDR_W-1:0] addr;
    case (op)
      OP_READ:  addr = {2'b00, page, col};
      OP_BUFWR: addr = {{(ADDR_W-COL_W){1'b0}}, col};
      default:  addr = {2'b00, page, {COL_W{1'b0}}};
    endcase
    frame_of = {opcode_of(op, bsel), addr, {FILL_W{1'b0}}};
  endfunction

  function automatic logic [CNT_W-1:0] frame_bits(fseq_op_e op);
    frame_bits = (op == OP_READ) ? CNT_W'(FRAME_W) : CNT_W'(8 + ADDR_W);
  endfunction

endpackage

// File: rtl/fseq_bit_engine.sv
module fseq_bit_engine
  import fseq_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] load_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               miso_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic [7:0]         rx_o,
  output logic               done_o
);

  localparam int unsigned HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic               active_q, active_d;
  logic               sck_q, sck_d;
  logic               done_q, done_d;
  logic [HC_W-1:0]    hcnt_q, hcnt_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [7:0]         rx_q, rx_d;
  logic               half_end;

  assign half_end = (hcnt_q == HC_W'(HALF_CYC - 1));

  always_comb begin
    active_d = active_q;
    sck_d    = sck_q;
    hcnt_d   = hcnt_q;
    left_d   = left_q;
    sreg_d   = sreg_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    if (go_i && !active_q) begin
      active_d = 1'b1;
      sck_d    = 1'b0;
      hcnt_d   = '0;
      left_d   = nbits_i;
      sreg_d   = load_i;
    end else if (active_q) begin
      if (!half_end) begin
        hcnt_d = hcnt_q + HC_W'(1);
      end else begin
        hcnt_d = '0;
        if (!sck_q) begin
          sck_d = 1'b1;
          rx_d  = {rx_q[6:0], miso_i};
        end else begin
          sck_d  = 1'b0;
          sreg_d = {sreg_q[FRAME_W-2:0], 1'b0};
          left_d = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            active_d = 1'b0;
            done_d   = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
      hcnt_q   <= '0;
      left_q   <= '0;
      sreg_q   <= '0;
      rx_q     <= '0;
    end else begin
      active_q <= active_d;
      sck_q    <= sck_d;
      done_q   <= done_d;
      hcnt_q   <= hcnt_d;
      left_q   <= left_d;
      sreg_q   <= sreg_d;
      rx_q     <= rx_d;
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = sreg_q[FRAME_W-1];
  assign rx_o   = rx_q;
  assign done_o = done_q;

  // R8: the device-bound data bit may not move while the clock is high
  a_r8_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(mosi_o));

  // R8: a finished burst leaves the clock low and the engine idle
  a_r8_done_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!sck_q && !active_q));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2,
  parameter int unsigned LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             buf_sel_i,
  input  logic [11:0]      page_i,
  input  logic [9:0]       byte_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_ready_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             busy_o,
  input  logic             flash_rdy_i,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             cs_n_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_FRAME, S_RD, S_WRW, S_WR, S_END
  } seq_state_e;

  // reset: asserted at once, released through two flops
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  seq_state_e         state_q, state_d;
  fseq_op_e           op_q, op_d;
  logic               bsel_q, bsel_d;
  logic [PAGE_W-1:0]  page_q, page_d;
  logic [COL_W-1:0]   col_q, col_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic               cs_n_q, cs_n_d;
  logic               rdv_q, rdv_d;
  logic [7:0]         rdd_q, rdd_d;

  logic               eng_go;
  logic [FRAME_W-1:0] eng_load;
  logic [CNT_W-1:0]   eng_nbits;
  logic [7:0]         eng_rx;
  logic               eng_done;

  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    bsel_d    = bsel_q;
    page_d    = page_q;
    col_d     = col_q;
    cnt_d     = cnt_q;
    cs_n_d    = cs_n_q;
    rdv_d     = 1'b0;
    rdd_d     = rdd_q;
    eng_go    = 1'b0;
    eng_load  = '0;
    eng_nbits = CNT_W'(8);
    case (state_q)
      S_IDLE: begin
        if (start_i && (fseq_op_e'(op_i) != OP_NONE)) begin
          op_d    = fseq_op_e'(op_i);
          bsel_d  = buf_sel_i;
          page_d  = page_i;
          col_d   = byte_i;
          cnt_d   = len_i;
          state_d = S_WAIT;
        end
      end
      S_WAIT: begin
        if (flash_rdy_i) begin
          eng_go    = 1'b1;
          eng_load  = frame_of(op_q, bsel_q, page_q, col_q);
          eng_nbits = frame_bits(op_q);
          cs_n_d    = 1'b0;
          state_d   = S_FRAME;
        end
      end
      S_FRAME: begin
        if (eng_done) begin
          if (op_q == OP_PROG || cnt_q == '0) begin
            cs_n_d  = 1'b1;
            state_d = S_END;
          end else if (op_q == OP_READ) begin
            eng_go  = 1'b1;
            state_d = S_RD;
          end else begin
            state_d = S_WRW;
          end
        end
      end
      S_RD: begin
        if (eng_done) begin
          rdv_d = 1'b1;
          rdd_d = eng_rx;
          cnt_d = cnt_q - LEN_W'(1);
          if (cnt_q == LEN_W'(1)) begin
            cs_n_d  = 1'b1;
            state_d = S_END;
          end else begin
            eng_go = 1'b1;
          end
        end
      end
      S_WRW: begin
        if (wr_valid_i) begin
          eng_go   = 1'b1;
          eng_load = {wr_data_i, {(FRAME_W-8){1'b0}}};
          state_d  = S_WR;
        end
      end
      S_WR: begin
        if (eng_done) begin
          cnt_d = cnt_q - LEN_W'(1);
          if (cnt_q == LEN_W'(1)) begin
            cs_n_d  = 1'b1;
            state_d = S_END;
          end else begin
            state_d = S_WRW;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= S_IDLE;
      op_q    <= OP_READ;
      bsel_q  <= 1'b0;
      page_q  <= '0;
      col_q   <= '0;
      cnt_q   <= '0;
      cs_n_q  <= 1'b1;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      bsel_q  <= bsel_d;
      page_q  <= page_d;
      col_q   <= col_d;
      cnt_q   <= cnt_d;
      cs_n_q  <= cs_n_d;
      rdv_q   <= rdv_d;
      rdd_q   <= rdd_d;
    end
  end

  fseq_bit_engine #(.HALF_CYC(HALF_CYC)) u_engine (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .go_i    (eng_go),
    .load_i  (eng_load),
    .nbits_i (eng_nbits),
    .miso_i  (miso_i),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .rx_o    (eng_rx),
    .done_o  (eng_done)
  );

  assign cs_n_o     = cs_n_q;
  assign busy_o     = (state_q != S_IDLE);
  assign wr_ready_o = (state_q == S_WRW);
  assign rd_valid_o = rdv_q;
  assign rd_data_o  = rdd_q;

  // R8: no clock edge toward a deselected device
  a_r8_clock_gated: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_n_o |-> !sck_o);

  // R1: an idle sequencer never holds the device selected
  a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> cs_n_o);

  // R6: write bytes are requested only inside a selected command
  a_r6_ready_in_cmd: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_ready_o |-> (busy_o && !cs_n_o));

  // R5: each read byte is announced for a single cycle
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_valid_o |=> !rd_valid_o);

  // R9: waiting for the device keeps it deselected
  a_r9_wait_deselect: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_WAIT) |-> (cs_n_o && !sck_o));

endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;

  localparam int HC = 1;
  localparam int LW = 3;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [1:0]    op_i;
  logic          buf_sel_i;
  logic [11:0]   page_i;
  logic [9:0]    byte_i;
  logic [LW-1:0] len_i;
  logic          wr_valid_i;
  logic [7:0]    wr_data_i;
  logic          wr_ready_o;
  logic          rd_valid_o;
  logic [7:0]    rd_data_o;
  logic          busy_o;
  logic          flash_rdy_i;
  logic          sck_o;
  logic          mosi_o;
  logic          miso_i;
  logic          cs_n_o;

  flash_cmd_seq #(.HALF_CYC(HC), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .buf_sel_i(buf_sel_i), .page_i(page_i), .byte_i(byte_i), .len_i(len_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .busy_o(busy_o),
    .flash_rdy_i(flash_rdy_i), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .cs_n_o(cs_n_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int nrise = 0;
  int ncs   = 0;
  int sck_bad = 0;
  int base  = 0;
  logic       cap [0:4095];
  logic [1:0] cur_op = 2'd3;
  logic [7:0] seed = 8'h00;

  function automatic logic [7:0] rd_pat(logic [7:0] s, int k);
    return 8'(int'(s) + k * 37 + 5);
  endfunction

  function automatic logic [7:0] wr_pat(logic [7:0] s, int k);
    return s ^ 8'(k * 29 + 1);
  endfunction

  // device model: capture on rising clock, drive read data on falling clock
  always @(posedge sck_o) begin
    if (cs_n_o) sck_bad = sck_bad + 1;
    else begin
      cap[nrise % 4096] = mosi_o;
      nrise = nrise + 1;
    end
  end

  always @(negedge sck_o) begin
    logic [7:0] b;
    int rel;
    rel = nrise - base;
    if (!cs_n_o && cur_op == 2'd0 && rel >= 64) begin
      b = rd_pat(seed, (rel - 64) / 8);
      miso_i = b[7 - ((rel - 64) % 8)];
    end
  end

  always @(negedge cs_n_o) ncs = ncs + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] pg_of(int i);
    case (i)
      0: return 12'h000;
      1: return 12'hfff;
      2: return 12'ha5c;
      default: return 12'h3c6;
    endcase
  endfunction

  function automatic logic [9:0] cl_of(int i);
    case (i)
      0: return 10'h000;
      1: return 10'h3ff;
      2: return 10'h2a5;
      default: return 10'h15a;
    endcase
  endfunction

  task automatic run_txn(input int op, input bit bs, input logic [11:0] pg,
                         input logic [9:0] cl, input int len,
                         input bit hold, input bit poke);
    int cs0, n, rk, wk, nb, expbits;
    bit poked;
    logic [31:0] act32, exp32, dum;
    logic [7:0] opc, db;
    string tag;
    @(negedge clk);
    base = nrise;
    cs0 = ncs;
    cur_op = 2'(op);
    seed = 8'(op * 71 + int'(pg[7:0]) + len * 13 + int'(bs));
    op_i = 2'(op); buf_sel_i = bs; page_i = pg; byte_i = cl; len_i = LW'(len);
    if (hold) flash_rdy_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (hold) begin
      repeat (20) @(negedge clk);
      chk(cs_n_o === 1'b1 && busy_o === 1'b1 && nrise == base, "R9",
          "held while not ready", {cs_n_o, busy_o}, 2'b11);
      flash_rdy_i = 1'b1;
    end
    n = 0; rk = 0; wk = 0; poked = 0;
    while (busy_o && n < 5000) begin
      @(negedge clk);
      n = n + 1;
      start_i = 1'b0;
      if (rd_valid_o) begin
        chk(rd_data_o == rd_pat(seed, rk), "R5", "read byte", rd_data_o, rd_pat(seed, rk));
        rk = rk + 1;
      end
      if (wr_valid_i) wr_valid_i = 1'b0;
      else if (wr_ready_o) begin
        wr_data_i = wr_pat(seed, wk);
        wr_valid_i = 1'b1;
        wk = wk + 1;
        if (poke && !poked) begin
          start_i = 1'b1; op_i = 2'd0; poked = 1;
        end
      end
    end
    if (n >= 5000) chk(0, "WDOG", "command never finished", n, 0);
    case (op)
      0: begin opc = 8'h52; tag = "R2"; exp32 = {opc, 2'b00, pg, cl}; end
      1: begin opc = bs ? 8'h87 : 8'h84; tag = "R3"; exp32 = {opc, 14'h0, cl}; end
      default: begin opc = bs ? 8'h86 : 8'h83; tag = "R4"; exp32 = {opc, 2'b00, pg, 10'h0}; end
    endcase
    for (int i = 0; i < 32; i++) act32[31-i] = cap[(base + i) % 4096];
    chk(act32 === exp32, tag, "opcode/address frame", act32, exp32);
    if (op == 0) begin
      for (int i = 0; i < 32; i++) dum[31-i] = cap[(base + 32 + i) % 4096];
      chk(dum === 32'h0, "R2", "filler bits", dum, 0);
      chk(rk == len, "R5", "read byte count", rk, len);
    end
    if (op == 1) begin
      chk(wk == len, "R6", "write byte count", wk, len);
      for (int k = 0; k < len; k++) begin
        for (int j = 0; j < 8; j++) db[7-j] = cap[(base + 32 + 8*k + j) % 4096];
        chk(db === wr_pat(seed, k), "R6", "write byte on wire", db, wr_pat(seed, k));
      end
    end
    nb = nrise - base;
    expbits = (op == 0) ? 64 + 8*len : (op == 1) ? 32 + 8*len : 32;
    chk(nb == expbits, (len == 0 && op != 2) ? "R7" : (op == 2 ? "R4" : tag),
        "clock count", nb, expbits);
    chk(ncs - cs0 == 1 && cs_n_o === 1'b1 && sck_o === 1'b0 && sck_bad == 0, "R8",
        "single select window", ncs - cs0, 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      chk(ncs - cs0 == 1 && busy_o === 1'b0, "R10", "start while busy ignored",
          ncs - cs0, 1);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    bad = bad + 1;
    total = total + 1;
    $display("FAIL WDOG global watchdog act=1 exp=0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'd0; buf_sel_i = 1'b0;
    page_i = '0; byte_i = '0; len_i = '0; wr_valid_i = 1'b0; wr_data_i = '0;
    flash_rdy_i = 1'b1; miso_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n_o === 1'b1 && sck_o === 1'b0 && busy_o === 1'b0, "R1",
        "state in reset", {cs_n_o, sck_o, busy_o}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n_o === 1'b1 && sck_o === 1'b0 && busy_o === 1'b0 &&
        wr_ready_o === 1'b0 && rd_valid_o === 1'b0, "R1", "state after reset",
        {cs_n_o, sck_o, busy_o, wr_ready_o, rd_valid_o}, 5'b10000);

    // sweep: operation x buffer x address pattern x length
    for (int op = 0; op < 3; op++)
      for (int bs = 0; bs < 2; bs++)
        for (int ai = 0; ai < 4; ai++)
          for (int li = 0; li < 3; li++)
            run_txn(op, bs[0], pg_of(ai), cl_of(ai), (li == 2) ? 3 : li, 1'b0, 1'b0);

    // R9: device not ready
    run_txn(0, 1'b0, 12'h5a5, 10'h0f0, 2, 1'b1, 1'b0);
    run_txn(2, 1'b1, 12'h321, 10'h000, 0, 1'b1, 1'b0);

    // R10: start during a buffer write
    run_txn(1, 1'b1, 12'h000, 10'h1c3, 3, 1'b0, 1'b1);

    // R10: reserved operation code
    begin
      int cs0;
      cs0 = ncs;
      @(negedge clk);
      op_i = 2'd3; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (10) @(negedge clk);
      chk(busy_o === 1'b0 && ncs == cs0, "R10", "reserved op ignored", ncs - cs0, 0);
    end

    // R1: reset in the middle of a read
    @(negedge clk);
    base = nrise; cur_op = 2'd0; seed = 8'h11;
    op_i = 2'd0; buf_sel_i = 1'b0; page_i = 12'h7ff; byte_i = 10'h001; len_i = LW'(3);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n_o === 1'b1 && sck_o === 1'b0 && busy_o === 1'b0, "R1",
        "abort by reset", {cs_n_o, sck_o, busy_o}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_txn(0, 1'b1, 12'h0ff, 10'h3c0, 1, 1'b0, 1'b0);

    finish_run();
  end

endmodule